// File: doc/BRIEF.md
# Late-Framed Serial PCM Stereo Receiver

This block takes stereo PCM audio from a three-wire serial link (bit clock, frame sync, serial data) and turns each frame into a pair of parallel sample words. It runs entirely on the bit clock. A frame begins on the first bit-clock rising edge that sees the frame sync high after it was low. That same edge captures the most significant bit of the left word. The remaining left bits follow, and the right word comes straight after them with no spare bit periods between the two. Both words arrive MSB first.

The sample length can be selected from four settings at run time. Each received word is placed at the top of a wide output word, and the unused low bits are cleared. When the last right bit has been taken, both words are loaded into the output registers together and a single-cycle valid strobe is raised. Serial data after the right word is ignored until the next frame starts. A frame that is cut short by a new sync edge is thrown away, and capture starts again on the new edge.

Top module: `pcm_late_rx`

## Requirements
- R1: While reset is asserted and after it is released, valid_o is 0 and left_o and right_o are all zeros until the first complete frame has been received.
- R2: After reset, no frame starts until the frame sync has been sampled low and then high on a later edge. A sync that is already high at the first edges after reset does not start a frame.
- R3: The left MSB is sampled on the same rising edge that first sees the frame sync high after low. The rest of the left bits follow MSB first, then the right bits MSB first, with the right MSB on the edge right after the left LSB.
- R4: valid_o is high in the cycle after the edge that samples the right LSB, which is the 2n-th capture edge counted from the start edge, where n is the word length.
- R5: wlen_sel_i selects the word length: 0 gives 16 bits, 1 gives 20, 2 gives 24 and 3 gives 32. Each word is left-aligned in its 32-bit output, with bit 31 holding the MSB and all bits below the LSB cleared to zero.
- R6: The word length is taken from wlen_sel_i on the start edge and used for the whole frame. Changing it during the frame has no effect on that frame.
- R7: A new sync rising edge before the right LSB throws away the partial frame. No valid is raised for it, and the new edge captures a fresh left MSB.
- R8: Bits that arrive after the right LSB and before the next sync rising edge are ignored. left_o and right_o keep their values between valid pulses.
- R9: valid_o lasts exactly one cycle per completed frame, and left_o and right_o are updated together on the edge that raises it.
- R10: A new frame may start on the edge right after the right LSB, provided the sync was sampled low on the LSB edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock. All sampling happens on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync_i | input | 1 | Frame sync. A low-to-high change marks the start of a frame |
| sdata_i | input | 1 | Serial audio data, MSB first |
| wlen_sel_i | input | 2 | Word length code: 0=16, 1=20, 2=24, 3=32 bits |
| left_o | output | 32 | Last complete left word, left-aligned |
| right_o | output | 32 | Last complete right word, left-aligned |
| valid_o | output | 1 | One-cycle strobe when a new pair of words is loaded |

## Verification
The bench first holds the sync high straight out of reset. A design that treated the reset state as "sync low" would then produce a spurious frame. It aborts frames partway and restarts them, and a design without a restart would merge the two frames or raise valid for the broken one. It changes the length code mid-frame, which catches a design that does not latch the length. It also sends frames back to back with no idle bits, where an off-by-one end count would swallow the next frame's MSB. All four lengths are run with random data, random sync widths and random junk in the idle bits. This exposes wrong zero fill, channels swapped into the wrong word, and idle bits leaking into the outputs.

// File: rtl/pcm_late_rx_pkg.sv
package pcm_late_rx_pkg;

   typedef enum logic [1:0] {
      WLEN_A = 2'd0,
      WLEN_B = 2'd1,
      WLEN_C = 2'd2,
      WLEN_D = 2'd3
   } wlen_code_e;

   typedef enum logic {
      CH_LEFT  = 1'b0,
      CH_RIGHT = 1'b1
   } chan_e;

   localparam int NUM_CH = 2;

endpackage

// File: rtl/pcm_sync_edge.sv
module pcm_sync_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic fsync_i,
   output logic start_o
);
   // previous sync level resets high so a sync already high after reset is no edge
   logic fs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fs_q <= 1'b1;
      else        fs_q <= fsync_i;
   end

   assign start_o = fsync_i & ~fs_q;
endmodule

// File: rtl/pcm_slot_seq.sv
module pcm_slot_seq
   import pcm_late_rx_pkg::*;
#(
   parameter int POS_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [POS_W-1:0] len_i,
   output logic             cap_en_o,
   output chan_e            chan_o,
   output logic [POS_W-1:0] pos_o,
   output logic             last_o
);
   logic             act_q;
   chan_e            chan_q;
   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] len_q;
   logic [POS_W-1:0] len_cur;
   logic             word_end;

   // the start edge itself carries the left MSB, so it overrides any frame in flight
   always_comb begin
      len_cur  = start_i ? len_i : len_q;
      cap_en_o = start_i | act_q;
      chan_o   = start_i ? CH_LEFT : chan_q;
      pos_o    = start_i ? '0 : pos_q;
      word_end = (pos_o == len_cur - POS_W'(1));
      last_o   = cap_en_o && (chan_o == CH_RIGHT) && word_end;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         chan_q <= CH_LEFT;
         pos_q  <= '0;
         len_q  <= '0;
      end else begin
         if (start_i) len_q <= len_i;
         if (cap_en_o) begin
            if (last_o) begin
               act_q  <= 1'b0;
               chan_q <= CH_LEFT;
               pos_q  <= '0;
            end else if (word_end) begin
               act_q  <= 1'b1;
               chan_q <= CH_RIGHT;
               pos_q  <= '0;
            end else begin
               act_q  <= 1'b1;
               chan_q <= chan_o;
               pos_q  <= pos_o + POS_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/pcm_lane.sv
module pcm_lane
   import pcm_late_rx_pkg::*;
#(
   parameter int    DATA_W = 32,
   parameter int    POS_W  = 6,
   parameter chan_e LANE   = CH_LEFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en_i,
   input  chan_e             chan_i,
   input  logic [POS_W-1:0]  pos_i,
   input  logic              sdata_i,
   output logic [DATA_W-1:0] word_nxt_o
);
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   logic [DATA_W-1:0] acc_q;
   logic [IDX_W-1:0]  idx;

   assign idx = IDX_W'(DATA_W - 1 - int'(pos_i));

   // first bit of a word clears the lane, which leaves the tail zero-filled
   always_comb begin
      word_nxt_o = acc_q;
      if (cap_en_i && (chan_i == LANE)) begin
         if (pos_i == '0) word_nxt_o = '0;
         word_nxt_o[idx] = sdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= word_nxt_o;
   end
endmodule

// File: rtl/pcm_frame_out.sv
module pcm_frame_out
   import pcm_late_rx_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          last_i,
   input  logic [NUM_CH-1:0][DATA_W-1:0] words_i,
   output logic [DATA_W-1:0]             left_o,
   output logic [DATA_W-1:0]             right_o,
   output logic                          valid_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_o  <= '0;
         right_o <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= last_i;
         if (last_i) begin
            left_o  <= words_i[CH_LEFT];
            right_o <= words_i[CH_RIGHT];
         end
      end
   end
endmodule

// File: rtl/pcm_late_rx.sv
module pcm_late_rx
   import pcm_late_rx_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LEN_A  = 16,
   parameter int LEN_B  = 20,
   parameter int LEN_C  = 24,
   parameter int LEN_D  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsync_i,
   input  logic              sdata_i,
   input  logic [1:0]        wlen_sel_i,
   output logic [DATA_W-1:0] left_o,
   output logic [DATA_W-1:0] right_o,
   output logic              valid_o
);
   localparam int POS_W = $clog2(DATA_W + 1);

   initial begin : elab_chk
      if (DATA_W < 2) $error("DATA_W must be at least 2");
      if (LEN_A < 1 || LEN_A > DATA_W) $error("LEN_A out of range");
      if (LEN_B < 1 || LEN_B > DATA_W) $error("LEN_B out of range");
      if (LEN_C < 1 || LEN_C > DATA_W) $error("LEN_C out of range");
      if (LEN_D < 1 || LEN_D > DATA_W) $error("LEN_D out of range");
   end

   function automatic logic [POS_W-1:0] len_decode(input wlen_code_e c);
      case (c)
         WLEN_A:  return POS_W'(LEN_A);
         WLEN_B:  return POS_W'(LEN_B);
         WLEN_C:  return POS_W'(LEN_C);
         default: return POS_W'(LEN_D);
      endcase
   endfunction

   logic                          start;
   logic                          cap_en;
   chan_e                         chan;
   logic [POS_W-1:0]              pos;
   logic                          last;
   logic [NUM_CH-1:0][DATA_W-1:0] words;

   pcm_sync_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .fsync_i (fsync_i),
      .start_o (start)
   );

   pcm_slot_seq #(.POS_W(POS_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .len_i    (len_decode(wlen_code_e'(wlen_sel_i))),
      .cap_en_o (cap_en),
      .chan_o   (chan),
      .pos_o    (pos),
      .last_o   (last)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
      pcm_lane #(
         .DATA_W (DATA_W),
         .POS_W  (POS_W),
         .LANE   (chan_e'(g))
      ) u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .cap_en_i   (cap_en),
         .chan_i     (chan),
         .pos_i      (pos),
         .sdata_i    (sdata_i),
         .word_nxt_o (words[g])
      );
   end

   pcm_frame_out #(.DATA_W(DATA_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .last_i  (last),
      .words_i (words),
      .left_o  (left_o),
      .right_o (right_o),
      .valid_o (valid_o)
   );
endmodule

// File: rtl/pcm_late_rx_chk.sv
module pcm_late_rx_chk #(
   parameter int DATA_W = 32,
   parameter int LEN_A  = 16,
   parameter int LEN_B  = 20,
   parameter int LEN_C  = 24,
   parameter int LEN_D  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fsync_i,
   input logic [1:0]        wlen_sel_i,
   input logic [DATA_W-1:0] left_o,
   input logic [DATA_W-1:0] right_o,
   input logic              valid_o
);
   localparam int CW = $clog2(2 * DATA_W + 2);

   function automatic int len_of(input logic [1:0] c);
      case (c)
         2'd0:    return LEN_A;
         2'd1:    return LEN_B;
         2'd2:    return LEN_C;
         default: return LEN_D;
      endcase
   endfunction

   function automatic logic [DATA_W-1:0] low_mask(input int n);
      logic [DATA_W-1:0] m;
      for (int i = 0; i < DATA_W; i++) m[i] = (i < DATA_W - n);
      return m;
   endfunction

   logic          fs_seen_q;
   logic          rose_q;
   logic [CW-1:0] since_q;
   int            len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_seen_q <= 1'b1;
         rose_q    <= 1'b0;
         since_q   <= '0;
         len_q     <= LEN_D;
      end else begin
         fs_seen_q <= fsync_i;
         if (fsync_i && !fs_seen_q) begin
            rose_q  <= 1'b1;
            since_q <= CW'(1);
            len_q   <= len_of(wlen_sel_i);
         end else if (since_q != '1) begin
            since_q <= since_q + CW'(1);
         end
      end
   end

   // R2: nothing completes before a real low-to-high sync change
   p_no_frame_before_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rose_q |-> !valid_o);

   // R4: valid lands exactly 2n edges after the start edge
   p_valid_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (int'(since_q) == 2 * len_q));

   // R5: bits below the LSB are zero in both words
   p_zero_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (((left_o | right_o) & low_mask(len_q)) == '0));

   // R8: outputs hold between valid pulses
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(left_o) && $stable(right_o)));

   // R9: valid is a single-cycle pulse
   p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
endmodule

bind pcm_late_rx pcm_late_rx_chk #(
   .DATA_W (DATA_W),
   .LEN_A  (LEN_A),
   .LEN_B  (LEN_B),
   .LEN_C  (LEN_C),
   .LEN_D  (LEN_D)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fsync_i    (fsync_i),
   .wlen_sel_i (wlen_sel_i),
   .left_o     (left_o),
   .right_o    (right_o),
   .valid_o    (valid_o)
);

// File: tb/sim_pcm_late_rx.sv
`timescale 1ns/1ps
module sim_pcm_late_rx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fsync = 1'b1;
   logic        sdata = 1'b0;
   logic [1:0]  wsel = 2'd0;
   logic [31:0] left, right;
   logic        valid;

   int          n_cmp = 0;
   int          n_bad = 0;
   bit          done = 1'b0;
   logic [31:0] exp_l = '0;
   logic [31:0] exp_r = '0;

   always #4 clk = ~clk;

   pcm_late_rx u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .fsync_i    (fsync),
      .sdata_i    (sdata),
      .wlen_sel_i (wsel),
      .left_o     (left),
      .right_o    (right),
      .valid_o    (valid)
   );

   function automatic int n_of(input logic [1:0] s);
      case (s)
         2'd0:    return 16;
         2'd1:    return 20;
         2'd2:    return 24;
         default: return 32;
      endcase
   endfunction

   function automatic logic [31:0] trunc(input logic [31:0] v, input int n);
      logic [63:0] m;
      m = ~((64'h1 << (32 - n)) - 64'h1);
      return v & m[31:0];
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // starts at a falling edge with fsync low on the previous bit
   task automatic run_frame(input logic [1:0] sel, input logic [31:0] l,
                            input logic [31:0] r, input int hw, input int gap,
                            input bit flip);
      int n;
      n = n_of(sel);
      wsel = sel;
      for (int i = 0; i < 2 * n; i++) begin
         fsync = (i < hw);
         sdata = (i < n) ? l[31 - i] : r[31 - (i - n)];
         if (flip && i == 3) wsel = sel + 2'd1;
         @(negedge clk);
         if (i < 2 * n - 1) chk("R4", "valid mid-frame", {31'b0, valid}, 32'd0);
      end
      exp_l = trunc(l, n);
      exp_r = trunc(r, n);
      chk("R4", "valid after right LSB", {31'b0, valid}, 32'd1);
      chk(flip ? "R6" : "R3", "left word", left, exp_l);
      chk(flip ? "R6" : "R5", "right word", right, exp_r);
      for (int g = 0; g < gap; g++) begin
         fsync = 1'b0;
         sdata = $urandom % 2;
         @(negedge clk);
         chk("R9", "valid after pulse", {31'b0, valid}, 32'd0);
         chk("R8", "left hold", left, exp_l);
         chk("R8", "right hold", right, exp_r);
      end
   endtask

   task automatic run_partial(input logic [1:0] sel, input int k);
      wsel = sel;
      for (int i = 0; i < k; i++) begin
         fsync = (i == 0);
         sdata = $urandom % 2;
         @(negedge clk);
         chk("R7", "valid on partial frame", {31'b0, valid}, 32'd0);
         chk("R7", "left during partial", left, exp_l);
      end
   endtask

   initial begin : watchdog
      #(8 * 150000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5A17));
      repeat (3) @(negedge clk);
      chk("R1", "valid in reset", {31'b0, valid}, 32'd0);
      chk("R1", "left in reset", left, 32'd0);
      chk("R1", "right in reset", right, 32'd0);
      rst_n = 1'b1;

      // R2: sync high from reset, never seen low
      for (int i = 0; i < 70; i++) begin
         sdata = $urandom % 2;
         @(negedge clk);
         chk("R2", "valid without sync edge", {31'b0, valid}, 32'd0);
      end
      chk("R1", "left after reset", left, 32'd0);
      chk("R1", "right after reset", right, 32'd0);
      fsync = 1'b0;
      @(negedge clk);

      // directed: each word length, known patterns
      run_frame(2'd0, 32'hA5C3_FFFF, 32'h1234_FFFF, 1, 3, 1'b0);
      run_frame(2'd1, 32'hFFFF_FFFF, 32'h8000_1000, 5, 2, 1'b0);
      run_frame(2'd2, 32'h8000_01FF, 32'h0000_01FF, 2, 4, 1'b0);
      run_frame(2'd3, 32'hDEAD_BEEF, 32'h0123_4567, 31, 2, 1'b0);
      // R10: back to back with no idle bits
      run_frame(2'd0, 32'h0001_0000, 32'hFFFE_0000, 1, 0, 1'b0);
      run_frame(2'd0, 32'h8000_0000, 32'h7FFF_0000, 1, 0, 1'b0);
      chk("R10", "back-to-back left", left, 32'h8000_0000);
      run_frame(2'd3, 32'h0000_0001, 32'h8000_0000, 1, 0, 1'b0);
      chk("R10", "back-to-back right", right, 32'h8000_0000);
      // R6: length code changed mid-frame
      run_frame(2'd0, 32'hCAFE_F00D, 32'hBEEF_1234, 2, 2, 1'b1);
      run_frame(2'd2, 32'h1357_9BDF, 32'h2468_ACE0, 3, 2, 1'b1);
      // R7: aborted frames
      run_partial(2'd1, 10);
      run_frame(2'd1, 32'h9999_9999, 32'h6666_6666, 1, 2, 1'b0);
      run_partial(2'd0, 25);
      run_frame(2'd3, 32'hF0F0_0F0F, 32'h3C3C_C3C3, 4, 1, 1'b0);
      chk("R7", "restarted frame left", left, 32'hF0F0_0F0F);
      run_partial(2'd3, 63);
      run_frame(2'd0, 32'h4321_0000, 32'h8765_0000, 1, 3, 1'b0);

      // random frames
      for (int f = 0; f < 200; f++) begin
         logic [1:0] s;
         int n;
         s = 2'($urandom % 4);
         n = n_of(s);
         if ($urandom % 8 == 0) run_partial(2'($urandom % 4), 2 + $urandom % 30);
         run_frame(s, $urandom, $urandom, 1 + $urandom % (2 * n - 1),
                   $urandom % 6, ($urandom % 10) == 0);
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule